// File: doc/BRIEF.md
# Write-back L1 cache controller

This block is the controller and storage for a small first-level data cache with four ways per set, write-back and write-allocate policies. It sits between a processor and a next-level cache. Both sides use the same word-wide request/ready handshake. The requester raises a valid strobe with an address, a direction bit and write data. The serving level answers with a one-cycle ready, along with read data when the request is a read. Each line holds four 32-bit words, there are 16 sets, and byte addresses split as tag `[31:8]`, set index `[7:4]`, word select `[3:2]` and byte bits `[1:0]`. The byte bits are not used.

Hits are answered in the cycle after the request is taken. A miss picks a victim way. If the victim is dirty, the whole line is copied into a one-line write buffer, and the buffer drains to the lower level one word per handshake. The missing line is fetched word by word only after the buffer is empty. A write miss merges the processor's word into the fetched line and leaves the line valid and dirty.

Top module: `l1_wb_cache`

## Requirements
- R1: After reset, `cpu_ready_o` and `mem_valid_o` are low and every line is invalid, so the first access to any address misses.
- R2: A read hit raises `cpu_ready_o` in the first cycle after the request is taken, returns the stored word and causes no lower-level traffic.
- R3: A write hit completes with the same one-cycle latency and no lower-level traffic. It replaces the addressed word and marks the line dirty, so the new value survives a later eviction.
- R4: A read miss issues four lower-level reads (`mem_rw_o` = 0) at the line base plus 0, 4, 8 and 12, in that order. It then returns the requested word.
- R5: A write miss first fetches the whole line, then merges the write data into the addressed word. The line becomes valid and dirty, and its other words keep the fetched values.
- R6: The victim is the lowest-numbered invalid way of the set. When all four ways are valid, it is the least recently used way.
- R7: A dirty victim is written back as four lower-level writes (`mem_rw_o` = 1) at its own line addresses in word order. All four writes come before the first read of the fill.
- R8: Evicting a clean victim causes no lower-level write.
- R9: `cpu_ready_o` is high for exactly one cycle per request.
- R10: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o`, `mem_addr_o` and `mem_rw_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor request strobe, held until ready |
| cpu_rw_i | input | 1 | Processor direction, 1 = write |
| cpu_addr_i | input | 32 | Processor byte address |
| cpu_wdata_i | input | 32 | Processor write word |
| cpu_rdata_o | output | 32 | Read word, valid with ready |
| cpu_ready_o | output | 1 | One-cycle completion to the processor |
| mem_valid_o | output | 1 | Lower-level request strobe |
| mem_rw_o | output | 1 | Lower-level direction, 1 = write |
| mem_addr_o | output | 32 | Lower-level word address (byte units) |
| mem_wdata_o | output | 32 | Lower-level write word |
| mem_rdata_i | input | 32 | Lower-level read word |
| mem_ready_i | input | 1 | One-cycle completion from the lower level |

## Verification
Two functions compete for the single lower-level port in the same window: draining the evicted dirty line and fetching the missing line. The bench provokes this by filling one set with four written lines and then reading a fifth tag in that set. The lower-level model delays every answer by several cycles, so the port is held while both functions are pending. The bench judges the result from the logged lower-level transactions. There must be four writes carrying the victim's words, including the merged one, before any read. The victim's data must also read back intact after it is fetched again.

// File: rtl/l1_cache_pkg.sv
package l1_cache_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_EVICT,
    S_FILL,
    S_DONE
  } ctl_state_e;
endpackage

// File: rtl/l1_tag_store.sv
module l1_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAY_W-1:0] vic_way_o,
  output logic             vic_valid_o,
  output logic             vic_dirty_o,
  output logic [TAG_W-1:0] vic_tag_o,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic             touch_i,
  input  logic             set_dirty_i,
  input  logic             install_i,
  input  logic [TAG_W-1:0] install_tag_i,
  input  logic             install_dirty_i
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  drt_q [SETS];
  logic [WAYS-1:0]  oldest;
  logic             free_found;

  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    vic_way_o  = '0;
    free_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      oldest[w] = (age_q[idx_i][w] == WAY_W'(WAYS - 1));
      if (vld_q[idx_i][w] && tag_q[idx_i][w] == tag_i) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
    end
    // invalid ways first, lowest index wins
    for (int w = 0; w < WAYS; w++) begin
      if (!free_found && !vld_q[idx_i][w]) begin
        free_found = 1'b1;
        vic_way_o  = WAY_W'(w);
      end
    end
    if (!free_found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (oldest[w]) vic_way_o = WAY_W'(w);
      end
    end
    vic_valid_o = vld_q[idx_i][vic_way_o];
    vic_dirty_o = drt_q[idx_i][vic_way_o];
    vic_tag_o   = tag_q[idx_i][vic_way_o];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        drt_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      if (install_i) begin
        vld_q[idx_i][upd_way_i] <= 1'b1;
        drt_q[idx_i][upd_way_i] <= install_dirty_i;
      end else if (set_dirty_i) begin
        drt_q[idx_i][upd_way_i] <= 1'b1;
      end
      if (touch_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == upd_way_i)
            age_q[idx_i][w] <= '0;
          else if (age_q[idx_i][w] < age_q[idx_i][upd_way_i])
            age_q[idx_i][w] <= age_q[idx_i][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (install_i) tag_q[idx_i][upd_way_i] <= install_tag_i;
  end

  // ages of a set stay a permutation: exactly one way is oldest
  p_one_oldest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(oldest));
endmodule

// File: rtl/l1_wbuf.sv
module l1_wbuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WPL    = 4,
  localparam int WRD_W  = $clog2(WPL),
  localparam int BYTE_W = $clog2(DATA_W / 8)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  logic [ADDR_W-1:0]     push_addr_i,
  input  logic [WPL*DATA_W-1:0] push_line_i,
  input  logic                  ack_i,
  output logic                  busy_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [DATA_W-1:0]     data_o
);
  logic                  busy_q;
  logic [WRD_W-1:0]      ptr_q;
  logic [ADDR_W-1:0]     base_q;
  logic [WPL*DATA_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      base_q <= '0;
      line_q <= '0;
    end else if (push_i) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
      base_q <= push_addr_i;
      line_q <= push_line_i;
    end else if (ack_i) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == WRD_W'(WPL - 1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = base_q | (ADDR_W'(ptr_q) << BYTE_W);
  assign data_o = line_q[ptr_q*DATA_W +: DATA_W];

  p_no_overwrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !busy_q);
  p_ack_when_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> busy_q);
endmodule

// File: rtl/l1_wb_cache.sv
module l1_wb_cache
  import l1_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int WPL    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_rw_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              mem_valid_o,
  output logic              mem_rw_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int WRD_W  = $clog2(WPL);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = WRD_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  ctl_state_e        state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_rw_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [WAY_W-1:0]  vic_way_q;
  logic [TAG_W-1:0]  vic_tag_q;
  logic [WRD_W-1:0]  cnt_q;
  logic              ready_q;
  logic [DATA_W-1:0] rdata_q;

  logic [DATA_W-1:0] data_q [SETS][WAYS][WPL];

  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [WRD_W-1:0]  cur_word;
  logic              unused_byte_bits;

  logic              hit;
  logic [WAY_W-1:0]  hit_way, vic_way;
  logic              vic_valid, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;

  logic              accept, fill_ack, wb_push, wb_busy;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic [WPL*DATA_W-1:0] vic_line;

  logic              dw_en;
  logic [WAY_W-1:0]  dw_way;
  logic [WRD_W-1:0]  dw_word;
  logic [DATA_W-1:0] dw_data;
  logic [DATA_W-1:0] rd_word;

  assign cur_addr         = (state_q == S_IDLE) ? cpu_addr_i : req_addr_q;
  assign cur_idx          = cur_addr[OFF_W +: IDX_W];
  assign cur_tag          = cur_addr[ADDR_W-1 -: TAG_W];
  assign cur_word         = cur_addr[BYTE_W +: WRD_W];
  assign unused_byte_bits = ^cur_addr[BYTE_W-1:0];

  assign accept   = (state_q == S_IDLE) && cpu_valid_i && !ready_q;
  assign fill_ack = (state_q == S_FILL) && !wb_busy && mem_ready_i;
  assign wb_push  = (state_q == S_EVICT) && !wb_busy;

  l1_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_tags (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .idx_i           (cur_idx),
    .tag_i           (cur_tag),
    .hit_o           (hit),
    .hit_way_o       (hit_way),
    .vic_way_o       (vic_way),
    .vic_valid_o     (vic_valid),
    .vic_dirty_o     (vic_dirty),
    .vic_tag_o       (vic_tag),
    .upd_way_i       ((state_q == S_DONE) ? vic_way_q : hit_way),
    .touch_i         ((accept && hit) || state_q == S_DONE),
    .set_dirty_i     (accept && hit && cpu_rw_i),
    .install_i       (state_q == S_DONE),
    .install_tag_i   (cur_tag),
    .install_dirty_i (req_rw_q)
  );

  always_comb begin
    for (int w = 0; w < WPL; w++)
      vic_line[w*DATA_W +: DATA_W] = data_q[cur_idx][vic_way_q][w];
  end

  l1_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WPL(WPL)) i_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wb_push),
    .push_addr_i ({vic_tag_q, cur_idx, OFF_W'(0)}),
    .push_line_i (vic_line),
    .ack_i       (wb_busy && mem_ready_i),
    .busy_o      (wb_busy),
    .addr_o      (wb_addr),
    .data_o      (wb_data)
  );

  // lower port: drain owns it until empty, then the fill
  assign mem_valid_o = wb_busy || (state_q == S_FILL);
  assign mem_rw_o    = wb_busy;
  assign mem_addr_o  = wb_busy ? wb_addr : {cur_tag, cur_idx, cnt_q, BYTE_W'(0)};
  assign mem_wdata_o = wb_busy ? wb_data : '0;

  always_comb begin
    dw_en   = 1'b0;
    dw_way  = hit_way;
    dw_word = cur_word;
    dw_data = cpu_wdata_i;
    if (accept && hit && cpu_rw_i) begin
      dw_en = 1'b1;
    end else if (fill_ack) begin
      dw_en   = 1'b1;
      dw_way  = vic_way_q;
      dw_word = cnt_q;
      dw_data = mem_rdata_i;
    end else if (state_q == S_DONE && req_rw_q) begin
      dw_en   = 1'b1;
      dw_way  = vic_way_q;
      dw_data = req_wdata_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (dw_en) data_q[cur_idx][dw_way][dw_word] <= dw_data;
  end

  assign rd_word = data_q[cur_idx][(state_q == S_DONE) ? vic_way_q : hit_way][cur_word];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      req_addr_q  <= '0;
      req_rw_q    <= 1'b0;
      req_wdata_q <= '0;
      vic_way_q   <= '0;
      vic_tag_q   <= '0;
      cnt_q       <= '0;
      ready_q     <= 1'b0;
      rdata_q     <= '0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          if (hit) begin
            ready_q <= 1'b1;
            if (!cpu_rw_i) rdata_q <= rd_word;
          end else begin
            req_addr_q  <= cpu_addr_i;
            req_rw_q    <= cpu_rw_i;
            req_wdata_q <= cpu_wdata_i;
            vic_way_q   <= vic_way;
            vic_tag_q   <= vic_tag;
            cnt_q       <= '0;
            state_q     <= (vic_valid && vic_dirty) ? S_EVICT : S_FILL;
          end
        end
        S_EVICT: if (!wb_busy) state_q <= S_FILL;
        S_FILL: if (fill_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == WRD_W'(WPL - 1)) state_q <= S_DONE;
        end
        S_DONE: begin
          ready_q <= 1'b1;
          if (!req_rw_q) rdata_q <= rd_word;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready_o = ready_q;
  assign cpu_rdata_o = rdata_q;

  p_hit_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> cpu_ready_o);
  p_ready_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o);
  p_lower_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_rw_o)));
endmodule

// File: tb/test_l1_wb_cache.sv
`timescale 1ns/1ps
module test_l1_wb_cache;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_valid = 1'b0, cpu_rw = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_valid, mem_rw;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  int n_chk = 0, n_fail = 0, hold_err = 0, lat = 0;
  logic [31:0] hold_addr;
  logic [31:0] mem_m [logic [31:0]];
  bit          log_rw [$];
  logic [31:0] log_a [$];
  logic [31:0] log_d [$];

  always #4 clk = ~clk;

  l1_wb_cache i_l1_wb_cache (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_valid_i(cpu_valid), .cpu_rw_i(cpu_rw), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready),
    .mem_valid_o(mem_valid), .mem_rw_o(mem_rw), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  function automatic logic [31:0] mval(input logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return {a[15:0], ~a[15:0]} ^ 32'h5a00_00a5;
  endfunction

  function automatic logic [31:0] ad(input int t, input int s, input int w);
    return 32'(t << 8) | 32'(s << 4) | 32'(w << 2);
  endfunction

  // always-hit lower level, three-cycle answer
  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_valid) begin
      if (lat == 0) hold_addr = mem_addr;
      else if (mem_addr !== hold_addr) hold_err++;
      if (lat == 2) begin
        lat = 0;
        log_rw.push_back(mem_rw);
        log_a.push_back(mem_addr);
        log_d.push_back(mem_wdata);
        if (mem_rw) mem_m[mem_addr] = mem_wdata;
        else mem_rdata = mval(mem_addr);
        mem_ready = 1'b1;
      end else lat++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    log_rw.delete(); log_a.delete(); log_d.delete();
  endtask

  task automatic access(input bit rw, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_rw = rw; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!cpu_ready && cyc < 1000);
    if (cyc >= 1000) chk("R9 timeout", 32'(cyc), 32'd0);
    rd = cpu_rdata;
    cpu_valid = 1'b0;
    @(negedge clk);
    chk("R9 ready pulse", 32'(cpu_ready), 32'd0);
  endtask

  task automatic chk_fill(input string req, input int first, input int t, input int s);
    for (int k = 0; k < 4; k++) begin
      chk({req, " fill rw"}, 32'(log_rw[first + k]), 32'd0);
      chk({req, " fill addr"}, log_a[first + k], ad(t, s, k));
    end
  endtask

  task automatic t_reset();
    chk("R1 ready low", 32'(cpu_ready), 32'd0);
    chk("R1 mem_valid low", 32'(mem_valid), 32'd0);
  endtask

  task automatic t_read_miss_hit();
    logic [31:0] rd; int cyc;
    clr_log();
    access(0, ad(1, 1, 2), 0, rd, cyc);
    chk("R1 first access misses", 32'(log_a.size()), 32'd4);
    chk_fill("R4", 0, 1, 1);
    chk("R4 miss data", rd, mval(ad(1, 1, 2)));
    clr_log();
    access(0, ad(1, 1, 3), 0, rd, cyc);
    chk("R2 hit latency", 32'(cyc), 32'd1);
    chk("R2 hit no traffic", 32'(log_a.size()), 32'd0);
    chk("R2 hit data", rd, mval(ad(1, 1, 3)));
  endtask

  task automatic t_lru_clean();
    logic [31:0] rd; int cyc;
    for (int t = 2; t <= 4; t++) begin
      clr_log();
      access(0, ad(t, 1, 0), 0, rd, cyc);
      chk("R6 free way used, no eviction", 32'(log_a.size()), 32'd4);
    end
    clr_log();
    access(0, ad(1, 1, 0), 0, rd, cyc);
    chk("R6 first line kept", 32'(log_a.size()), 32'd0);
    clr_log();
    access(0, ad(5, 1, 1), 0, rd, cyc);
    chk("R8 clean victim traffic", 32'(log_a.size()), 32'd4);
    chk_fill("R8", 0, 5, 1);
    foreach (log_rw[i]) chk("R8 no write", 32'(log_rw[i]), 32'd0);
    chk("R4 data after eviction", rd, mval(ad(5, 1, 1)));
    for (int t = 1; t <= 4; t++) begin
      clr_log();
      access(0, ad(t == 2 ? 1 : t, 1, 0), 0, rd, cyc);
      chk("R6 recent lines stay", 32'(log_a.size()), 32'd0);
    end
    clr_log();
    access(0, ad(2, 1, 0), 0, rd, cyc);
    chk("R6 LRU line was evicted", 32'(log_a.size()), 32'd4);
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int cyc;
    clr_log();
    access(1, ad(3, 1, 2), 32'hc0de_0003, rd, cyc);
    chk("R3 write hit latency", 32'(cyc), 32'd1);
    chk("R3 write hit no traffic", 32'(log_a.size()), 32'd0);
    access(0, ad(3, 1, 2), 0, rd, cyc);
    chk("R3 write hit readback", rd, 32'hc0de_0003);
  endtask

  task automatic t_write_miss_evict();
    logic [31:0] rd; int cyc;
    logic [31:0] exp_wb [4];
    clr_log();
    access(1, ad(1, 2, 1), 32'hbeef_0001, rd, cyc);
    chk("R5 write miss fetches", 32'(log_a.size()), 32'd4);
    chk_fill("R5", 0, 1, 2);
    clr_log();
    access(0, ad(1, 2, 1), 0, rd, cyc);
    chk("R5 merged word", rd, 32'hbeef_0001);
    chk("R5 line valid", 32'(log_a.size()), 32'd0);
    access(0, ad(1, 2, 2), 0, rd, cyc);
    chk("R5 other word kept", rd, mval(ad(1, 2, 2)));
    for (int t = 2; t <= 4; t++) access(1, ad(t, 2, 0), 32'(t), rd, cyc);
    for (int k = 0; k < 4; k++)
      exp_wb[k] = (k == 1) ? 32'hbeef_0001 : mval(ad(1, 2, k));
    clr_log();
    access(0, ad(5, 2, 3), 0, rd, cyc);
    chk("R7 transfer count", 32'(log_a.size()), 32'd8);
    if (log_a.size() == 8) begin
      for (int k = 0; k < 4; k++) begin
        chk("R7 writeback rw", 32'(log_rw[k]), 32'd1);
        chk("R7 writeback addr", log_a[k], ad(1, 2, k));
        chk("R7 writeback data", log_d[k], exp_wb[k]);
      end
      chk_fill("R7", 4, 5, 2);
    end
    chk("R4 data", rd, mval(ad(5, 2, 3)));
    clr_log();
    access(0, ad(1, 2, 1), 0, rd, cyc);
    chk("R7 dirty line refetched", rd, 32'hbeef_0001);
    chk("R5 dirty after write miss", 32'(log_rw.size() > 0 ? log_rw[0] : 1'b0), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss_hit();
    t_lru_clean();
    t_write_hit();
    t_write_miss_evict();
    chk("R10 lower request held", 32'(hold_err), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule